// File: doc/BRIEF.md
# SMBus Clock-Low, Bus-Idle and Stretch Timeout Detector

This block sits beside an I2C/SMBus protocol engine. It times bus conditions in cycles of the kernel clock. Its SCL and SDA inputs must already be synchronized to that clock.

Timer A has a 12-bit reload value and a mode bit, and it runs in one of two modes:
- **SCL-low mode (mode 0):** it measures how long SCL has been held low without a break.
- **Bus-idle mode (mode 1):** it measures how long SCL and SDA have both been high without a break.

Timer B also has a 12-bit reload value. It adds up the cycles in which the local engine is stretching the clock, across the whole transfer. It starts again from zero at every start or stop indication. One reload value serves both the master and the slave limits, and software chooses it so that detection comes before the bus maximum.

Each timer has its own enable. While a timer is enabled, its configuration is locked. Each timer drives a sticky flag that software clears with a one-cycle pulse, plus a one-cycle event pulse. Timer A also drives a bus-idle level. The block has no data stream, so every pin is a plain control or status signal, with no valid/ready handshake and no back-pressure.

Top module: `smb_tmo_top`

## Requirements
- R1: Timer A advances only while `ta_en` is 1. While `ta_en` is 0, its progress is discarded, so the timeout flag never sets however long the bus condition lasts.
- R2: With mode 0 (SCL-low), `tmo_flag` reads 1 on the cycle after the (A+1)·2048+1-th consecutive clock edge that samples `scl_in` low. Any edge that samples `scl_in` high restarts the count.
- R3: With mode 1 (bus idle), `tmo_flag` reads 1 on the cycle after the (A+1)·4+1-th consecutive edge that samples both `scl_in` and `sda_in` high. Any edge that samples either line low restarts the count.
- R4: `bus_idle` is 1 in mode 1 from the cycle the idle timeout fires until the first edge that samples SCL or SDA low. It is 0 at all times in mode 0.
- R5: Timer B adds one for each edge that samples `stretch_in` high, and keeps its total across gaps in stretching. `ext_flag` reads 1 after the (B+1)·2048+1-th such edge.
- R6: Timer B's total goes back to zero on any edge that samples `start_stop_in` high, or `tb_en` low.
- R7: `tmo_flag` and `ext_flag` reset to 0 and stay set until a one-cycle `tmo_clr` or `ext_clr` pulse. A new timeout on the same edge as a clear pulse leaves the flag set.
- R8: `tmo_pulse` and `ext_pulse` are each high for exactly one cycle, on the cycle their flag goes from 0 to 1.
- R9: A write to Timer A's configuration (`ta_wr`, with the reload value in `ta_wdata_reload` and the mode in `ta_wdata_mode`) is ignored while `ta_en` is 1. The stored values can be read on `ta_reload` and `ta_mode`.
- R10: A write to Timer B's reload value (`tb_wr`, `tb_wdata_reload`) is ignored while `tb_en` is 1. The stored value can be read on `tb_reload`.
- R11: A timer fires only once per episode of its condition. If its flag is cleared while the condition continues, the flag stays 0 until the condition has ended and built up again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| stretch_in | input | 1 | Local engine is holding SCL low to stretch |
| start_stop_in | input | 1 | Start or stop condition seen (one cycle) |
| ta_en | input | 1 | Timer A enable |
| ta_wr | input | 1 | Timer A configuration write strobe |
| ta_wdata_reload | input | 12 | Timer A reload value to write |
| ta_wdata_mode | input | 1 | Timer A mode to write: 0 = SCL low, 1 = bus idle |
| tb_en | input | 1 | Timer B enable |
| tb_wr | input | 1 | Timer B configuration write strobe |
| tb_wdata_reload | input | 12 | Timer B reload value to write |
| tmo_clr | input | 1 | Clear pulse for the Timer A flag |
| ext_clr | input | 1 | Clear pulse for the Timer B flag |
| ta_reload | output | 12 | Stored Timer A reload value |
| ta_mode | output | 1 | Stored Timer A mode |
| tb_reload | output | 12 | Stored Timer B reload value |
| tmo_flag | output | 1 | Sticky Timer A timeout flag |
| tmo_pulse | output | 1 | One-cycle pulse when `tmo_flag` sets |
| ext_flag | output | 1 | Sticky Timer B cumulative-stretch flag |
| ext_pulse | output | 1 | One-cycle pulse when `ext_flag` sets |
| bus_idle | output | 1 | Bus-idle level (mode 1 only) |

## Verification
The assertions assume the following about the inputs:
- The bus lines and the strobes are already synchronous to the kernel clock and do not change at the clock edge.
- The clear inputs are single-cycle pulses, as software writes produce.

The bench drives every input on the falling edge. It issues each clear and start/stop indication as a one-cycle pulse. It also attempts configuration writes both while a timer is enabled and while it is disabled, so the lock assertions see both cases.

// File: rtl/smb_tmo_pkg.sv
package smb_tmo_pkg;
  typedef enum logic {
    TA_SCL_LOW  = 1'b0,
    TA_BUS_IDLE = 1'b1
  } ta_mode_e;

  function automatic int unsigned presc_bits(input int unsigned factor);
    return (factor <= 2) ? 1 : $clog2(factor);
  endfunction
endpackage

// File: rtl/smb_tmo_cfg.sv
module smb_tmo_cfg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  // A configuration write only takes effect while the timer is stopped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (wr && !en) q <= wdata;
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(q)); // R9, R10
endmodule

// File: rtl/smb_tmo_cnt.sv
module smb_tmo_cnt #(
  parameter int unsigned RLD_W      = 12,
  parameter int unsigned PRE_W      = 11,
  parameter bit          CUMULATIVE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cond,
  input  logic [PRE_W-1:0] presc_last,
  input  logic [RLD_W-1:0] limit,
  output logic             hit,
  output logic             done
);
  localparam int unsigned MAJ_W = RLD_W + 1;

  logic [PRE_W-1:0] pre_q;
  logic [MAJ_W-1:0] maj_q;
  logic [MAJ_W-1:0] target;

  assign target = MAJ_W'(limit) + MAJ_W'(1);
  assign hit    = !clr && cond && !done && (maj_q == target) && (pre_q == '0);

  generate
    if (CUMULATIVE) begin : g_accumulate
      // The total is kept through gaps in the condition; only clr empties it.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || clr) begin
          pre_q <= '0; maj_q <= '0; done <= 1'b0;
        end else if (cond && !done) begin
          if (hit)                    done  <= 1'b1;
          else if (pre_q == presc_last) begin
            pre_q <= '0; maj_q <= maj_q + MAJ_W'(1);
          end else                    pre_q <= pre_q + PRE_W'(1);
        end
      end
    end else begin : g_consecutive
      // Any break in the condition starts the measurement again.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || clr) begin
          pre_q <= '0; maj_q <= '0; done <= 1'b0;
        end else if (!cond) begin
          pre_q <= '0; maj_q <= '0; done <= 1'b0;
        end else if (!done) begin
          if (hit)                    done  <= 1'b1;
          else if (pre_q == presc_last) begin
            pre_q <= '0; maj_q <= maj_q + MAJ_W'(1);
          end else                    pre_q <= pre_q + PRE_W'(1);
        end
      end
    end
  endgenerate

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (maj_q == '0 && pre_q == '0 && !done)); // R1, R6
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr && cond) |=> (done && $stable(maj_q))); // R11
  AST_HIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit); // R11
endmodule

// File: rtl/smb_tmo_flag.sv
module smb_tmo_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag,
  output logic pulse
);
  // A set on the same edge as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      flag  <= set || (flag && !clr);
      pulse <= set && !flag;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R8
  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (flag && !$past(flag))); // R8
endmodule

// File: rtl/smb_tmo_top.sv
module smb_tmo_top
  import smb_tmo_pkg::*;
#(
  parameter int unsigned RLD_W      = 12,
  parameter int unsigned LOW_PRESC  = 2048,
  parameter int unsigned IDLE_PRESC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             stretch_in,
  input  logic             start_stop_in,
  input  logic             ta_en,
  input  logic             ta_wr,
  input  logic [RLD_W-1:0] ta_wdata_reload,
  input  logic             ta_wdata_mode,
  input  logic             tb_en,
  input  logic             tb_wr,
  input  logic [RLD_W-1:0] tb_wdata_reload,
  input  logic             tmo_clr,
  input  logic             ext_clr,
  output logic [RLD_W-1:0] ta_reload,
  output logic             ta_mode,
  output logic [RLD_W-1:0] tb_reload,
  output logic             tmo_flag,
  output logic             tmo_pulse,
  output logic             ext_flag,
  output logic             ext_pulse,
  output logic             bus_idle
);
  localparam int unsigned PRE_W = presc_bits(LOW_PRESC);
  localparam logic [PRE_W-1:0] LOW_LAST  = PRE_W'(LOW_PRESC - 1);
  localparam logic [PRE_W-1:0] IDLE_LAST = PRE_W'(IDLE_PRESC - 1);

  logic [RLD_W:0]   ta_cfg_q;
  logic             a_cond, a_hit, a_done;
  logic             b_hit, b_done, b_clr;
  logic [PRE_W-1:0] a_presc_last;
  ta_mode_e         a_mode;

  smb_tmo_cfg #(.W(RLD_W + 1)) u_cfg_a (
    .clk(clk), .rst_n(rst_n), .en(ta_en), .wr(ta_wr),
    .wdata({ta_wdata_mode, ta_wdata_reload}), .q(ta_cfg_q)
  );

  smb_tmo_cfg #(.W(RLD_W)) u_cfg_b (
    .clk(clk), .rst_n(rst_n), .en(tb_en), .wr(tb_wr),
    .wdata(tb_wdata_reload), .q(tb_reload)
  );

  assign ta_reload    = ta_cfg_q[RLD_W-1:0];
  assign ta_mode      = ta_cfg_q[RLD_W];
  assign a_mode       = ta_mode_e'(ta_cfg_q[RLD_W]);
  assign a_cond       = (a_mode == TA_BUS_IDLE) ? (scl_in && sda_in) : !scl_in;
  assign a_presc_last = (a_mode == TA_BUS_IDLE) ? IDLE_LAST : LOW_LAST;

  smb_tmo_cnt #(.RLD_W(RLD_W), .PRE_W(PRE_W), .CUMULATIVE(1'b0)) u_cnt_a (
    .clk(clk), .rst_n(rst_n), .clr(!ta_en), .cond(a_cond),
    .presc_last(a_presc_last), .limit(ta_reload), .hit(a_hit), .done(a_done)
  );

  assign b_clr = !tb_en || start_stop_in;

  smb_tmo_cnt #(.RLD_W(RLD_W), .PRE_W(PRE_W), .CUMULATIVE(1'b1)) u_cnt_b (
    .clk(clk), .rst_n(rst_n), .clr(b_clr), .cond(stretch_in),
    .presc_last(LOW_LAST), .limit(tb_reload), .hit(b_hit), .done(b_done)
  );

  smb_tmo_flag u_flag_a (
    .clk(clk), .rst_n(rst_n), .set(a_hit), .clr(tmo_clr),
    .flag(tmo_flag), .pulse(tmo_pulse)
  );

  smb_tmo_flag u_flag_b (
    .clk(clk), .rst_n(rst_n), .set(b_hit), .clr(ext_clr),
    .flag(ext_flag), .pulse(ext_pulse)
  );

  assign bus_idle = (a_mode == TA_BUS_IDLE) && a_done;

  AST_NO_COUNT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ta_en |=> !tmo_pulse); // R1
  AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ta_mode && !(scl_in && sda_in)) |=> !bus_idle); // R4
  AST_IDLE_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !ta_mode |-> !bus_idle); // R4
  AST_EXT_CLEARED_BY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_stop_in || !tb_en) |=> !ext_pulse); // R6
  AST_B_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (b_done && !b_clr) |=> b_done); // R5
endmodule

// File: tb/smb_tmo_top_bench.sv
module smb_tmo_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1, stretch_in = 1'b0, start_stop_in = 1'b0;
  logic ta_en = 1'b0, ta_wr = 1'b0, ta_wdata_mode = 1'b0;
  logic [11:0] ta_wdata_reload = '0, tb_wdata_reload = '0;
  logic tb_en = 1'b0, tb_wr = 1'b0, tmo_clr = 1'b0, ext_clr = 1'b0;
  logic [11:0] ta_reload, tb_reload;
  logic ta_mode, tmo_flag, tmo_pulse, ext_flag, ext_pulse, bus_idle;

  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;

  always #5 clk = ~clk;

  smb_tmo_top u_smb_tmo_top (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .stretch_in(stretch_in), .start_stop_in(start_stop_in),
    .ta_en(ta_en), .ta_wr(ta_wr), .ta_wdata_reload(ta_wdata_reload),
    .ta_wdata_mode(ta_wdata_mode), .tb_en(tb_en), .tb_wr(tb_wr),
    .tb_wdata_reload(tb_wdata_reload), .tmo_clr(tmo_clr), .ext_clr(ext_clr),
    .ta_reload(ta_reload), .ta_mode(ta_mode), .tb_reload(tb_reload),
    .tmo_flag(tmo_flag), .tmo_pulse(tmo_pulse), .ext_flag(ext_flag),
    .ext_pulse(ext_pulse), .bus_idle(bus_idle)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge.
  int m_ra = 0, m_rb = 0, m_mode = 0;
  int a_run = 0, b_acc = 0;
  bit a_fired = 0, b_fired = 0;
  bit m_tmo = 0, m_tmo_p = 0, m_ext = 0, m_ext_p = 0, m_idle = 0;

  always @(posedge clk) begin
    bit ev_a, ev_b, cond_a;
    int per;
    ev_a = 0; ev_b = 0;
    if (!rst_n) begin
      m_ra = 0; m_rb = 0; m_mode = 0; a_run = 0; b_acc = 0;
      a_fired = 0; b_fired = 0;
      m_tmo = 0; m_tmo_p = 0; m_ext = 0; m_ext_p = 0; m_idle = 0;
    end else begin
      per    = (m_mode != 0) ? 4 : 2048;
      cond_a = (m_mode != 0) ? (scl_in && sda_in) : !scl_in;
      if (!ta_en || !cond_a) begin
        a_run = 0; a_fired = 0;
      end else if (!a_fired) begin
        a_run++;
        if (a_run == (m_ra + 1) * per + 1) begin ev_a = 1; a_fired = 1; end
      end
      if (!tb_en || start_stop_in) begin
        b_acc = 0; b_fired = 0;
      end else if (stretch_in && !b_fired) begin
        b_acc++;
        if (b_acc == (m_rb + 1) * 2048 + 1) begin ev_b = 1; b_fired = 1; end
      end
      m_tmo_p = ev_a && !m_tmo;
      m_tmo   = ev_a || (m_tmo && !tmo_clr);
      m_ext_p = ev_b && !m_ext;
      m_ext   = ev_b || (m_ext && !ext_clr);
      if (ta_wr && !ta_en) begin m_ra = ta_wdata_reload; m_mode = ta_wdata_mode; end
      if (tb_wr && !tb_en) m_rb = tb_wdata_reload;
      m_idle = (m_mode != 0) && a_fired;
    end
  end

  // Compare every output with the model after each edge settles.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done_run) begin
      chk(tmo_flag == m_tmo, "R2/R3 tmo_flag", tmo_flag, m_tmo);
      chk(tmo_pulse == m_tmo_p, "R8 tmo_pulse", tmo_pulse, m_tmo_p);
      chk(ext_flag == m_ext, "R5 ext_flag", ext_flag, m_ext);
      chk(ext_pulse == m_ext_p, "R8 ext_pulse", ext_pulse, m_ext_p);
      chk(bus_idle == m_idle, "R4 bus_idle", bus_idle, m_idle);
      chk(ta_reload == 12'(m_ra) && ta_mode == m_mode[0], "R9 cfg A", ta_reload, m_ra);
      chk(tb_reload == 12'(m_rb), "R10 cfg B", tb_reload, m_rb);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tclr();
    tmo_clr = 1; cyc(1); tmo_clr = 0;
  endtask

  task automatic pulse_eclr();
    ext_clr = 1; cyc(1); ext_clr = 0;
  endtask

  task automatic wr_a(input int rl, input bit md);
    ta_wr = 1; ta_wdata_reload = 12'(rl); ta_wdata_mode = md; cyc(1); ta_wr = 0;
  endtask

  task automatic wr_b(input int rl);
    tb_wr = 1; tb_wdata_reload = 12'(rl); cyc(1); tb_wr = 0;
  endtask

  task automatic summary();
    done_run = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk(!tmo_flag && !ext_flag && !bus_idle, "R7 reset", tmo_flag, 0);

    // R2: SCL held low, reload 0, mode 0
    wr_a(0, 0);
    ta_en = 1;
    scl_in = 0;
    cyc(2048);
    chk(tmo_flag == 0, "R2 not yet", tmo_flag, 0);
    cyc(1);
    chk(tmo_flag == 1, "R2 fires", tmo_flag, 1);
    chk(tmo_pulse == 1, "R8 pulse high", tmo_pulse, 1);
    cyc(1);
    chk(tmo_pulse == 0, "R8 pulse single", tmo_pulse, 0);
    // R11: clear while still low, no refire
    pulse_tclr();
    cyc(200);
    chk(tmo_flag == 0, "R11 no refire", tmo_flag, 0);
    // R2 restart on high
    scl_in = 1; cyc(1); scl_in = 0; cyc(1500);
    scl_in = 1; cyc(1); scl_in = 0; cyc(1500);
    chk(tmo_flag == 0, "R2 restart", tmo_flag, 0);
    scl_in = 1; cyc(1);

    // R9: locked write ignored
    wr_a(5, 1);
    chk(ta_reload == 0 && ta_mode == 0, "R9 locked", ta_reload, 0);
    // R1: disabled timer never fires
    ta_en = 0;
    scl_in = 0; cyc(3000);
    chk(tmo_flag == 0, "R1 disabled", tmo_flag, 0);
    scl_in = 1;
    wr_a(1, 1);
    chk(ta_reload == 1 && ta_mode == 1, "R9 write ok", ta_reload, 1);

    // R3/R4: bus idle, reload 1 -> 8 cycles
    ta_en = 1;
    cyc(5); sda_in = 0; cyc(1); sda_in = 1;
    cyc(8);
    chk(tmo_flag == 0 && bus_idle == 0, "R3 not yet", tmo_flag, 0);
    tmo_clr = 1; cyc(1); tmo_clr = 0;
    chk(tmo_flag == 1, "R7 set wins over clear", tmo_flag, 1);
    chk(bus_idle == 1, "R4 idle high", bus_idle, 1);
    cyc(10);
    chk(bus_idle == 1, "R4 idle held", bus_idle, 1);
    sda_in = 0; cyc(1);
    chk(bus_idle == 0, "R4 idle drops", bus_idle, 0);
    chk(tmo_flag == 1, "R7 sticky", tmo_flag, 1);
    sda_in = 1;
    pulse_tclr();
    chk(tmo_flag == 0, "R7 cleared", tmo_flag, 0);
    ta_en = 0;

    // R5: cumulative stretch, reload 0
    wr_b(0);
    tb_en = 1;
    wr_b(7);
    chk(tb_reload == 0, "R10 locked", tb_reload, 0);
    stretch_in = 1; cyc(1000); stretch_in = 0; cyc(500);
    stretch_in = 1; cyc(1048);
    chk(ext_flag == 0, "R5 not yet", ext_flag, 0);
    cyc(1);
    chk(ext_flag == 1 && ext_pulse == 1, "R5 fires", ext_flag, 1);
    stretch_in = 0;
    pulse_eclr();
    chk(ext_flag == 0, "R7 ext cleared", ext_flag, 0);

    // R6: start/stop and disable reset the total
    start_stop_in = 1; cyc(1); start_stop_in = 0;
    stretch_in = 1; cyc(2000); stretch_in = 0;
    start_stop_in = 1; cyc(1); start_stop_in = 0;
    stretch_in = 1; cyc(2000); stretch_in = 0;
    chk(ext_flag == 0, "R6 start clears", ext_flag, 0);
    tb_en = 0; cyc(1); tb_en = 1;
    stretch_in = 1; cyc(2000); stretch_in = 0; cyc(5);
    chk(ext_flag == 0, "R6 disable clears", ext_flag, 0);
    tb_en = 0;
    wr_b(3);
    chk(tb_reload == 3, "R10 write ok", tb_reload, 3);
    cyc(5);
    summary();
  end
endmodule